// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a physical address. It reads a four-level table tree from memory. It starts when it sees a one-cycle start pulse. The start pulse comes with the virtual address, a root register, an access kind, a user flag and a no-execute enable.

The walker reads one 64-bit entry per level through a request/response memory port. It checks each entry for presence and for reserved bits. It ANDs or ORs the permission bits from every level it visits. A walk stops early at a 1 GB or 2 MB leaf, or it continues to a 4 KB leaf. On the way it writes accessed and dirty bits back into the tables. It finishes with a one-cycle done pulse. With that pulse it gives either a translation (address, size code, permission vector) or a fault with a fault code.

The block is used as the miss handler behind a translation cache. It holds one walk at a time. It keeps no state between walks apart from its result registers.

Top module: `page_walker`

## Requirements
- R1: The first entry is read from the root register with its low 12 bits cleared, plus 8 times the index. Each later entry is read from the address field (bits 51:12) of the previous entry, plus 8 times its index. The indices are virtual address bits 47:39, 38:30, 29:21 and 20:12, used from the top level down.
- R2: An entry whose bit 0 (present) is clear ends the walk with a fault. The fault code bit 0 and bit 3 are then 0.
- R3: An entry has a reserved-bit fault in any of these cases: an address-field bit at or above PA_BITS (bits 51:PA_BITS) is set; bit 63 is set while no-execute is disabled; bit 7 is set in a top-level entry. The fault code then has bit 3 and bit 0 set. When no-execute is enabled, bit 63 is legal.
- R4: In a 1 GB leaf, address bits 29:13 are reserved, and in a 2 MB leaf, bits 20:13 are reserved. A set bit there gives a reserved-bit fault. Bit 12 stays legal in both cases.
- R5: Bit 7 set in a level-3 entry ends the walk with a 1 GB page (size code 2). Bit 7 set in a level-2 entry gives a 2 MB page (code 1). Otherwise the level-1 entry gives a 4 KB page (code 0).
- R6: A non-leaf entry whose bit 5 (accessed) is clear is written back with bit 5 set before the next level is read. An entry with bit 5 already set is not written.
- R7: The leaf entry is written once, and only if something changes. The write sets bit 5 if it is clear and, on a write access, sets bit 6 (dirty) if it is clear.
- R8: The permission vector is {execute, user, writable}, in bits 2:0. Writable is the AND of bit 1 over all levels. User is the AND of bit 2 over all levels. Execute is the inverse of the OR of bit 63 over all levels.
- R9: If the leaf's dirty bit was clear and the access is not a write, the writable bit of the result is 0.
- R10: The physical address is the leaf's address field with the bits below the page size cleared. The virtual address bits below the page size are then added in.
- R11: Fault code bit 1 is set on a write access (access kind 1) and bit 2 on a user access. Bit 4 is set on a fetch (access kind 2), but only while no-execute is enabled. Access kind 0 is a read.
- R12: A memory request holds its valid, address and kind until ready is seen. A read waits for its response before anything else starts. Done is high for exactly one cycle, and fault is high only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| startReq | input | 1 | One-cycle pulse that starts a walk |
| virtAddr | input | VA_BITS | Virtual address to translate |
| tableRoot | input | 64 | Root pointer of the table tree |
| accessKind | input | 2 | 0 read, 1 write, 2 fetch |
| userAccess | input | 1 | Access made at user privilege |
| nxEnable | input | 1 | No-execute enable |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | 64 | Byte address of the entry |
| memReqData | output | 64 | Write data |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 64 | Read data |
| walkDone | output | 1 | One-cycle completion pulse |
| walkFault | output | 1 | Walk ended in a fault, valid with walkDone |
| faultCode | output | 5 | {fetch, reserved, user, write, protection} |
| physAddr | output | PA_BITS | Translated address |
| pageSize | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| permBits | output | 3 | {execute, user, writable} |

## Verification
The hardest cases are a leaf that needs a combined accessed-and-dirty write-back and a walk that needs no write at all. These depend on the state the tables were left in by earlier walks. The bench therefore runs a read walk and then a write walk over the same tables. The first walk sets the accessed bits. The second walk then sees exactly one write, to the leaf, which adds the dirty bit. Reserved-bit cases need entries built on purpose at one chosen level. Examples are a bit above the physical width, a low bit inside a 2 MB frame, and no-execute with the feature disabled. The memory model stalls ready on some cycles and answers reads late, so request holding is exercised on every walk.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RDREQ, ST_RDWAIT, ST_CHECK, ST_WRNODE, ST_WRLEAF, ST_DONE
  } walkState_t;

  // strobes from control into datapath
  typedef struct packed {
    logic loadStart;
    logic latchEntry;
    logic accumPerm;
    logic descend;
    logic captureLeaf;
    logic captureFault;
  } walkStrobe_t;

  // decode results from datapath to control
  typedef struct packed {
    logic notPresent;
    logic rsvdHit;
    logic isLeaf;
    logic nodeNeedsA;
    logic leafNeedsWrite;
  } walkFlags_t;

  localparam int BIT_P  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_U  = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;
  localparam int BIT_PS = 7;
  localparam int BIT_ATTR = 12;
  localparam int BIT_NX = 63;

  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;
  localparam logic [63:0] ADDR_FIELD = 64'h000F_FFFF_FFFF_F000;
endpackage

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int VA_BITS    = 48,
  parameter int PA_BITS    = 40,
  parameter int LEVELS     = 4,
  parameter int IDX_BITS   = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int LARGE_MAX  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobe_t         strobe,
  input  logic [VA_BITS-1:0]  virtAddr,
  input  logic [63:0]         tableRoot,
  input  logic [1:0]          accessKind,
  input  logic                userAccess,
  input  logic                nxEnable,
  input  logic [63:0]         memRespData,
  output walkFlags_t          flags,
  output logic [63:0]         entryAddr,
  output logic [63:0]         writeData,
  output logic                faultFlag,
  output logic [4:0]          faultCode,
  output logic [PA_BITS-1:0]  physAddr,
  output logic [1:0]          pageSize,
  output logic [2:0]          permBits
);
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ENT_SHIFT = 3;
  localparam logic [63:0] PHYS_MASK = (64'd1 << PA_BITS) - 64'd1;
  localparam logic [63:0] HIGH_RSVD = ADDR_FIELD & ~PHYS_MASK;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  logic [VA_BITS-1:0] vaQ;
  logic [63:0]        baseQ, entryQ;
  logic [LVL_W-1:0]   lvlQ;
  logic [1:0]         kindQ;
  logic               userQ, nxeQ;
  logic               accW, accU, accNx;

  logic [LEVELS-1:0][IDX_BITS-1:0] idxOf;
  for (genvar k = 0; k < LEVELS; k++) begin : g_idx
    assign idxOf[k] = vaQ[PAGE_SHIFT + k*IDX_BITS +: IDX_BITS];
  end

  logic        isWrite, psBit, largeLeaf, psIllegal;
  logic [63:0] spanMask, rsvdMask, vaWide, leafPa;
  logic        nextW, nextU, nextNx;

  always_comb begin
    isWrite   = (kindQ == ACC_WRITE);
    psBit     = entryQ[BIT_PS];
    psIllegal = psBit && (lvlQ > LVL_W'(LARGE_MAX));
    largeLeaf = psBit && (lvlQ != '0) && !psIllegal;
    spanMask  = (64'd1 << (PAGE_SHIFT + int'(lvlQ) * IDX_BITS)) - 64'd1;
    vaWide    = 64'(vaQ);

    rsvdMask = HIGH_RSVD;
    if (!nxeQ)     rsvdMask[BIT_NX] = 1'b1;
    if (psIllegal) rsvdMask[BIT_PS] = 1'b1;
    if (largeLeaf) rsvdMask = rsvdMask | (spanMask & ADDR_FIELD & ~(64'd1 << BIT_ATTR));

    flags.notPresent     = !entryQ[BIT_P];
    flags.rsvdHit        = |(entryQ & rsvdMask);
    flags.isLeaf         = (lvlQ == '0) || largeLeaf;
    flags.nodeNeedsA     = !entryQ[BIT_A];
    flags.leafNeedsWrite = !entryQ[BIT_A] || (isWrite && !entryQ[BIT_D]);

    entryAddr = baseQ | (64'(idxOf[lvlQ]) << ENT_SHIFT);
    writeData = entryQ | (64'd1 << BIT_A);
    if (flags.isLeaf && isWrite) writeData[BIT_D] = 1'b1;

    nextW  = accW & entryQ[BIT_W];
    nextU  = accU & entryQ[BIT_U];
    nextNx = accNx | entryQ[BIT_NX];
    leafPa = (entryQ & ADDR_FIELD & PHYS_MASK & ~spanMask) | (vaWide & spanMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ <= '0; baseQ <= '0; entryQ <= '0; lvlQ <= TOP_LVL;
      kindQ <= '0; userQ <= 1'b0; nxeQ <= 1'b0;
      accW <= 1'b1; accU <= 1'b1; accNx <= 1'b0;
      faultFlag <= 1'b0; faultCode <= '0;
      physAddr <= '0; pageSize <= '0; permBits <= '0;
    end else begin
      if (strobe.loadStart) begin
        vaQ   <= virtAddr;
        baseQ <= tableRoot & ~64'hFFF;
        lvlQ  <= TOP_LVL;
        kindQ <= accessKind;
        userQ <= userAccess;
        nxeQ  <= nxEnable;
        accW  <= 1'b1; accU <= 1'b1; accNx <= 1'b0;
        faultFlag <= 1'b0;
        faultCode <= '0;
      end
      if (strobe.latchEntry) entryQ <= memRespData;
      if (strobe.accumPerm) begin
        accW <= nextW; accU <= nextU; accNx <= nextNx;
      end
      if (strobe.descend) begin
        baseQ <= entryQ & ADDR_FIELD;
        lvlQ  <= lvlQ - 1'b1;
      end
      if (strobe.captureLeaf) begin
        physAddr <= leafPa[PA_BITS-1:0];
        pageSize <= 2'(lvlQ);
        permBits <= {~nextNx, nextU, nextW & (entryQ[BIT_D] | isWrite)};
      end
      if (strobe.captureFault) begin
        faultFlag <= 1'b1;
        faultCode <= {(kindQ == ACC_FETCH) && nxeQ,
                      !flags.notPresent && flags.rsvdHit,
                      userQ, isWrite,
                      !flags.notPresent && flags.rsvdHit};
      end
    end
  end
endmodule

// File: rtl/pgw_control.sv
module pgw_control
  import pgw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        memReqReady,
  input  logic        memRespValid,
  input  walkFlags_t  flags,
  output walkStrobe_t strobe,
  output logic        reqValid,
  output logic        reqWrite,
  output logic        doneNow
);
  walkState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    reqValid = 1'b0;
    reqWrite = 1'b0;
    doneNow  = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (startReq) begin
        strobe.loadStart = 1'b1;
        stateD = ST_RDREQ;
      end
      ST_RDREQ: begin
        reqValid = 1'b1;
        if (memReqReady) stateD = ST_RDWAIT;
      end
      ST_RDWAIT: if (memRespValid) begin
        strobe.latchEntry = 1'b1;
        stateD = ST_CHECK;
      end
      ST_CHECK: begin
        if (flags.notPresent || flags.rsvdHit) begin
          strobe.captureFault = 1'b1;
          stateD = ST_DONE;
        end else begin
          strobe.accumPerm = 1'b1;
          if (flags.isLeaf) begin
            strobe.captureLeaf = 1'b1;
            stateD = flags.leafNeedsWrite ? ST_WRLEAF : ST_DONE;
          end else if (flags.nodeNeedsA) begin
            stateD = ST_WRNODE;
          end else begin
            strobe.descend = 1'b1;
            stateD = ST_RDREQ;
          end
        end
      end
      ST_WRNODE: begin
        reqValid = 1'b1;
        reqWrite = 1'b1;
        if (memReqReady) begin
          strobe.descend = 1'b1;
          stateD = ST_RDREQ;
        end
      end
      ST_WRLEAF: begin
        reqValid = 1'b1;
        reqWrite = 1'b1;
        if (memReqReady) stateD = ST_DONE;
      end
      ST_DONE: begin
        doneNow = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pgw_pkg::*;
#(
  parameter int VA_BITS    = 48,
  parameter int PA_BITS    = 40,
  parameter int LEVELS     = 4,
  parameter int IDX_BITS   = 9,
  parameter int PAGE_SHIFT = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [VA_BITS-1:0] virtAddr,
  input  logic [63:0]        tableRoot,
  input  logic [1:0]         accessKind,
  input  logic               userAccess,
  input  logic               nxEnable,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic               memReqWrite,
  output logic [63:0]        memReqAddr,
  output logic [63:0]        memReqData,
  input  logic               memRespValid,
  input  logic [63:0]        memRespData,
  output logic               walkDone,
  output logic               walkFault,
  output logic [4:0]         faultCode,
  output logic [PA_BITS-1:0] physAddr,
  output logic [1:0]         pageSize,
  output logic [2:0]         permBits
);
  walkStrobe_t strobe;
  walkFlags_t  flags;
  logic        faultFlag;

  pgw_control uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .memReqReady(memReqReady), .memRespValid(memRespValid),
    .flags(flags), .strobe(strobe),
    .reqValid(memReqValid), .reqWrite(memReqWrite), .doneNow(walkDone)
  );

  pgw_datapath #(
    .VA_BITS(VA_BITS), .PA_BITS(PA_BITS), .LEVELS(LEVELS),
    .IDX_BITS(IDX_BITS), .PAGE_SHIFT(PAGE_SHIFT)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .virtAddr(virtAddr), .tableRoot(tableRoot), .accessKind(accessKind),
    .userAccess(userAccess), .nxEnable(nxEnable), .memRespData(memRespData),
    .flags(flags), .entryAddr(memReqAddr), .writeData(memReqData),
    .faultFlag(faultFlag), .faultCode(faultCode),
    .physAddr(physAddr), .pageSize(pageSize), .permBits(permBits)
  );

  assign walkFault = walkDone & faultFlag;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int VA_BITS = 48,
  parameter int PA_BITS = 40
) (
  input logic               clk,
  input logic               rstN,
  input logic               memReqValid,
  input logic               memReqReady,
  input logic               memReqWrite,
  input logic [63:0]        memReqAddr,
  input logic [63:0]        memReqData,
  input logic               walkDone,
  input logic               walkFault,
  input logic [1:0]         pageSize
);
  // R12: request held stable while stalled
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqWrite));

  // R12: done lasts one cycle
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |=> !walkDone);

  // R12: fault only together with done
  assert_fault_with_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    walkFault |-> walkDone);

  // R12: no memory traffic in the done cycle
  assert_quiet_at_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |-> !memReqValid);

  // R1: entry addresses are 8-byte aligned
  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'b000);

  // R6 / R7: every write-back carries the accessed bit
  assert_write_sets_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite |-> memReqData[5]);

  // R5: size code is one of three legal values
  assert_size_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    walkDone && !walkFault |-> pageSize != 2'd3);
endmodule

bind page_walker pgw_checker #(.VA_BITS(VA_BITS), .PA_BITS(PA_BITS)) uChk (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqData(memReqData),
  .walkDone(walkDone), .walkFault(walkFault), .pageSize(pageSize)
);

// File: tb/tb_page_walker.sv
module tb_page_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] P = 64'h1, W = 64'h2, U = 64'h4, A = 64'h20, D = 64'h40, PS = 64'h80;
  localparam logic [63:0] NX = 64'h8000_0000_0000_0000;

  logic clk = 0, rstN = 0, startReq = 0;
  logic [47:0] virtAddr = '0;
  logic [63:0] tableRoot = 64'h1ABC;
  logic [1:0] accessKind = 0;
  logic userAccess = 0, nxEnable = 0;
  logic memReqValid, memReqReady, memReqWrite, memRespValid;
  logic [63:0] memReqAddr, memReqData, memRespData;
  logic walkDone, walkFault;
  logic [4:0] faultCode;
  logic [39:0] physAddr;
  logic [1:0] pageSize;
  logic [2:0] permBits;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_walker dut (.*);

  typedef struct {
    string tag; logic isFault; logic [4:0] code;
    logic [39:0] pa; logic [1:0] size; logic [2:0] perm;
  } expItem_t;
  expItem_t expQ[$];

  logic [63:0] mem [longint unsigned];
  int total = 0, bad = 0, doneCount = 0, wrCount = 0, cyc = 0, pendCnt = 0;
  logic [63:0] pendData;

  task automatic check(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: stalls ready, answers reads after a delay
  initial begin
    memReqReady = 0; memRespValid = 0; memRespData = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (rstN && memReqValid && memReqReady) begin
        if (memReqWrite) begin
          mem[memReqAddr] = memReqData;
          wrCount++;
        end else begin
          pendData = mem.exists(memReqAddr) ? mem[memReqAddr] : 64'd0;
          pendCnt = 2;
        end
      end
      memRespValid <= 1'b0;
      if (pendCnt > 0) begin
        pendCnt--;
        if (pendCnt == 0) begin
          memRespValid <= 1'b1;
          memRespData  <= pendData;
        end
      end
      memReqReady <= (cyc % 3) != 0;
    end
  end

  // monitor: compares each completion against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && walkDone) begin
        expItem_t e;
        if (expQ.size() == 0) begin
          check("R12 unexpected done", 1'b0, 64'd1, 64'd0);
        end else begin
          e = expQ.pop_front();
          check({e.tag, " fault"}, walkFault == e.isFault, 64'(walkFault), 64'(e.isFault));
          if (e.isFault) begin
            check({e.tag, " code"}, faultCode == e.code, 64'(faultCode), 64'(e.code));
          end else begin
            check({e.tag, " addr"}, physAddr == e.pa, 64'(physAddr), 64'(e.pa));
            check({e.tag, " size"}, pageSize == e.size, 64'(pageSize), 64'(e.size));
            check({e.tag, " perm"}, permBits == e.perm, 64'(permBits), 64'(e.perm));
          end
        end
        doneCount++;
      end
    end
  end

  task automatic runWalk(input logic [47:0] va, input logic [1:0] kind, input logic usr,
                         input logic nxe, input expItem_t e, input int expWrites, input string wtag);
    int target, w0;
    expQ.push_back(e);
    w0 = wrCount;
    target = doneCount + 1;
    @(negedge clk);
    virtAddr = va; accessKind = kind; userAccess = usr; nxEnable = nxe; startReq = 1;
    @(negedge clk);
    startReq = 0;
    while (doneCount < target) @(negedge clk);
    if (expWrites >= 0)
      check({wtag, " write count"}, (wrCount - w0) == expWrites, 64'(wrCount - w0), 64'(expWrites));
  endtask

  function automatic expItem_t ok(string t, logic [39:0] pa, logic [1:0] sz, logic [2:0] pm);
    expItem_t e; e.tag = t; e.isFault = 0; e.code = 0; e.pa = pa; e.size = sz; e.perm = pm; return e;
  endfunction
  function automatic expItem_t flt(string t, logic [4:0] c);
    expItem_t e; e.tag = t; e.isFault = 1; e.code = c; e.pa = 0; e.size = 0; e.perm = 0; return e;
  endfunction

  function automatic logic [47:0] mkVa(int i4, int i3, int i2, int i1, logic [11:0] off);
    return (48'(i4) << 39) | (48'(i3) << 30) | (48'(i2) << 21) | (48'(i1) << 12) | 48'(off);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset done low", walkDone == 0, 64'(walkDone), 0);
    check("R12 reset req low", memReqValid == 0, 64'(memReqValid), 0);
    rstN = 1;
    @(negedge clk);

    // R1 R6 R9 R10: 4 KB read walk, accessed bits clear everywhere
    mem[64'h1008] = 64'h2000 | P | W | U;
    mem[64'h2010] = 64'h3000 | P | W | U;
    mem[64'h3018] = 64'h4000 | P | W | U;
    mem[64'h4020] = 64'h12_3456_7000 | P | W | U;
    runWalk(mkVa(1,2,3,4,12'h123), 2'd0, 0, 0, ok("R1 R10 4K read", 40'h12_3456_7123, 2'd0, 3'b110), 4, "R6");
    check("R6 top entry accessed", mem[64'h1008] == (64'h2000|P|W|U|A), mem[64'h1008], 64'h2000|P|W|U|A);
    check("R7 leaf accessed only", mem[64'h4020] == (64'h12_3456_7000|P|W|U|A), mem[64'h4020], 64'h12_3456_7000|P|W|U|A);

    // R7: write over same tables, only the leaf changes (dirty)
    runWalk(mkVa(1,2,3,4,12'h123), 2'd1, 0, 0, ok("R8 4K write", 40'h12_3456_7123, 2'd0, 3'b111), 1, "R7");
    check("R7 leaf dirty", mem[64'h4020] == (64'h12_3456_7000|P|W|U|A|D), mem[64'h4020], 64'h12_3456_7000|P|W|U|A|D);

    // R5 R8: 2 MB leaf, all bits already set, no writes; user bit missing above
    mem[64'h1028] = 64'h5000 | P | W | A;
    mem[64'h5030] = 64'h6000 | P | W | A;
    mem[64'h6038] = 64'h40_0020_0000 | P | W | U | A | D | PS;
    runWalk(mkVa(5,6,7,8'h12,12'h345), 2'd0, 0, 0, ok("R5 2M", 40'h40_0021_2345, 2'd1, 3'b101), 0, "R7 no change");

    // R4 R5 R8: 1 GB leaf with attribute bit, no-execute at the top level
    mem[64'h1040] = 64'h7000 | P | W | U | A | NX;
    mem[64'h7048] = 64'h80_4000_0000 | P | W | U | PS | 64'h1000;
    runWalk((48'd8 << 39) | (48'd9 << 30) | 48'h2345_6789, 2'd0, 0, 1,
            ok("R4 1G attr bit", 40'h80_6345_6789, 2'd2, 3'b010), 1, "R7 1G");
    check("R7 1G leaf accessed", mem[64'h7048][5] == 1'b1, mem[64'h7048], 64'h20);

    // R2 R11: not-present at level 2, user write
    mem[64'h1050] = 64'h8000 | P | W | U;
    mem[64'h8058] = 64'h9000 | P | W | U;
    runWalk(mkVa(10,11,12,0,0), 2'd1, 1, 0, flt("R2 R11 not present", 5'b00110), 2, "R6 before fault");

    // R3 R11: bit above physical width in a level-3 entry, fetch with nx on
    mem[64'h1068] = 64'hA000 | P | W | U | A;
    mem[64'hA000] = 64'hB000 | P | W | U | A | (64'd1 << 45);
    runWalk(mkVa(13,0,0,0,0), 2'd2, 0, 1, flt("R3 R11 high rsvd fetch", 5'b11001), 0, "R3");

    // R3: page-size bit at the top level
    mem[64'h1070] = 64'hC000 | P | W | A | PS;
    runWalk(mkVa(14,0,0,0,0), 2'd0, 0, 0, flt("R3 top PS", 5'b01001), 0, "R3 top");

    // R3: no-execute bit with nx disabled, then legal with nx enabled
    mem[64'h1078] = 64'hD000 | P | W | A;
    mem[64'hD008] = 64'hE000 | P | W | A;
    mem[64'hE008] = 64'hF000 | P | W | A;
    mem[64'hF008] = 64'h10_0000 | P | W | A | NX;
    runWalk(mkVa(15,1,1,1,0), 2'd0, 0, 0, flt("R3 nx disabled", 5'b01001), 0, "R3 nx");
    runWalk(mkVa(15,1,1,1,0), 2'd0, 0, 1, ok("R3 R9 nx enabled", 40'h10_0000, 2'd0, 3'b000), 0, "R9");

    // R4: low address bit inside a 2 MB frame
    mem[64'h1080] = 64'h11000 | P | W | A;
    mem[64'h11010] = 64'h12000 | P | W | A;
    mem[64'h12018] = 64'h60_0000 | P | W | A | D | PS | 64'h2000;
    runWalk(mkVa(16,2,3,0,0), 2'd0, 0, 0, flt("R4 2M low rsvd", 5'b01001), 0, "R4");

    // R2 R11: missing top entry, fetch with nx off gives no fetch bit
    runWalk(mkVa(17,0,0,0,0), 2'd2, 0, 0, flt("R2 R11 fetch nx off", 5'b00000), 0, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule